// File: doc/BRIEF.md
# Multi-Field Transaction Traffic Filter

This block decides, for every observed bus transaction, whether it should count toward a traffic statistic. Each transaction carries five fields: an 8-bit initiator identifier, a 7-bit target identifier, a few user-information bits, an opcode bit that tells a load from a store, and a small error code. The aggregation counter downstream only needs a yes/no answer per filter, and this block supplies it.

The block contains several unit filters. Each one holds its own configuration: a mask and a match value for each of the four numeric fields, plus one enable for loads and one for stores. A field passes when the bits selected by its mask equal the same bits of its match value. A unit hits when all four fields pass and the opcode is allowed. The per-unit results are gated by the transaction-valid input and registered, so each unit's hit bit appears one clock after the transaction is presented.

Top module: `trf_filter`

## Requirements
- R1: In the clock cycle after a cycle with `rst` high, every bit of `hit_o` is 0.
- R2: For the initiator identifier, the field passes exactly when ((txn_init_id XOR match) AND mask) is zero. The unit's 8-bit slice is taken from bits [u*8 +: 8] of the initiator mask and match ports.
- R3: The target identifier passes by the same rule, using 7-bit slices [u*7 +: 7].
- R4: The user-information bits pass by the same rule, using 4-bit slices [u*4 +: 4].
- R5: The error code passes by the same rule, using 2-bit slices [u*2 +: 2].
- R6: A mask of all zeros makes that field pass for any value; with every mask at zero, only the opcode qualifiers decide the outcome.
- R7: `txn_store` = 0 marks a load and `txn_store` = 1 marks a store. A load is allowed only if `cfg_rd_en[u]` is 1. A store is allowed only if `cfg_wr_en[u]` is 1. If both enables are 0, the unit never hits. If both are 1, either opcode is allowed.
- R8: A unit hits only when all four field tests pass and the opcode is allowed. If any single test fails, the unit does not hit.
- R9: When `txn_valid` is 0, every hit bit that results from that cycle is 0, whatever the fields hold.
- R10: `hit_o` is registered. Its value after rising edge N reflects the inputs sampled at edge N, so there is one cycle of latency.
- R11: Each unit depends only on its own configuration slice. For the same transaction, two units with different configurations can return different results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_valid | input | 1 | A transaction is present this cycle |
| txn_init_id | input | 8 | Initiator identifier |
| txn_tgt_id | input | 7 | Target identifier |
| txn_user | input | 4 | User-information bits |
| txn_store | input | 1 | Opcode: 0 for load, 1 for store |
| txn_err | input | 2 | Error code |
| cfg_init_mask | input | 8*NUM_UNITS | Per-unit initiator mask |
| cfg_init_match | input | 8*NUM_UNITS | Per-unit initiator match value |
| cfg_tgt_mask | input | 7*NUM_UNITS | Per-unit target mask |
| cfg_tgt_match | input | 7*NUM_UNITS | Per-unit target match value |
| cfg_user_mask | input | 4*NUM_UNITS | Per-unit user-info mask |
| cfg_user_match | input | 4*NUM_UNITS | Per-unit user-info match value |
| cfg_err_mask | input | 2*NUM_UNITS | Per-unit error mask |
| cfg_err_match | input | 2*NUM_UNITS | Per-unit error match value |
| cfg_rd_en | input | NUM_UNITS | Per-unit load enable |
| cfg_wr_en | input | NUM_UNITS | Per-unit store enable |
| hit_o | output | NUM_UNITS | Registered per-unit hit vector |

## Verification
Exercising a single field in isolation is the hardest case to reach. It needs a transaction whose other three fields all pass while exactly one bit of the field under test differs under its mask. Uniformly random configurations almost never produce that, so the random stimulus copies the transaction into the match values and then flips, with some probability, one random bit per field. This produces a steady mix of hits and near misses. Directed cases add all-zero masks, both opcode enables off, valid held low, and two units that disagree on the same transaction.

// File: rtl/trf_pkg.sv
package trf_pkg;

    localparam int INIT_W    = 8;
    localparam int TGT_W     = 7;
    localparam int USER_W    = 4;
    localparam int ERR_W     = 2;
    localparam int NUM_UNITS = 2;

    typedef struct packed {
        logic [INIT_W-1:0] init_id;
        logic [TGT_W-1:0]  tgt_id;
        logic [USER_W-1:0] user;
        logic              is_store;
        logic [ERR_W-1:0]  err;
    } txn_t;

    typedef struct packed {
        logic [INIT_W-1:0] init_mask;
        logic [INIT_W-1:0] init_match;
        logic [TGT_W-1:0]  tgt_mask;
        logic [TGT_W-1:0]  tgt_match;
        logic [USER_W-1:0] user_mask;
        logic [USER_W-1:0] user_match;
        logic [ERR_W-1:0]  err_mask;
        logic [ERR_W-1:0]  err_match;
        logic              rd_en;
        logic              wr_en;
    } unit_cfg_t;

    // Index of the per-field pass bits inside a unit
    typedef enum logic [1:0] {
        FLD_INIT = 2'd0,
        FLD_TGT  = 2'd1,
        FLD_USER = 2'd2,
        FLD_ERR  = 2'd3
    } field_e;

    localparam int NUM_FIELDS = 4;

    function automatic logic opcode_allowed(input logic is_store,
                                            input logic rd_en,
                                            input logic wr_en);
        return is_store ? wr_en : rd_en;
    endfunction

endpackage

// File: rtl/trf_field_cmp.sv
module trf_field_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] field_i,
    input  logic [W-1:0] mask_i,
    input  logic [W-1:0] match_i,
    output logic         pass_o
);
    logic [W-1:0] diff;

    always_comb begin
        diff   = (field_i ^ match_i) & mask_i;
        pass_o = (diff == '0);
    end
endmodule

// File: rtl/trf_unit.sv
module trf_unit
    import trf_pkg::*;
(
    input  txn_t      txn_i,
    input  unit_cfg_t cfg_i,
    output logic      pass_o
);
    logic [NUM_FIELDS-1:0] fld_ok;
    logic                  op_ok;

    trf_field_cmp #(.W(INIT_W)) u_cmp_init (
        .field_i(txn_i.init_id), .mask_i(cfg_i.init_mask),
        .match_i(cfg_i.init_match), .pass_o(fld_ok[FLD_INIT])
    );
    trf_field_cmp #(.W(TGT_W)) u_cmp_tgt (
        .field_i(txn_i.tgt_id), .mask_i(cfg_i.tgt_mask),
        .match_i(cfg_i.tgt_match), .pass_o(fld_ok[FLD_TGT])
    );
    trf_field_cmp #(.W(USER_W)) u_cmp_user (
        .field_i(txn_i.user), .mask_i(cfg_i.user_mask),
        .match_i(cfg_i.user_match), .pass_o(fld_ok[FLD_USER])
    );
    trf_field_cmp #(.W(ERR_W)) u_cmp_err (
        .field_i(txn_i.err), .mask_i(cfg_i.err_mask),
        .match_i(cfg_i.err_match), .pass_o(fld_ok[FLD_ERR])
    );

    always_comb begin
        op_ok  = opcode_allowed(txn_i.is_store, cfg_i.rd_en, cfg_i.wr_en);
        pass_o = (&fld_ok) & op_ok;
    end
endmodule

// File: rtl/trf_filter.sv
module trf_filter
    import trf_pkg::*;
#(
    parameter int NU = NUM_UNITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 txn_valid,
    input  logic [INIT_W-1:0]    txn_init_id,
    input  logic [TGT_W-1:0]     txn_tgt_id,
    input  logic [USER_W-1:0]    txn_user,
    input  logic                 txn_store,
    input  logic [ERR_W-1:0]     txn_err,
    input  logic [NU*INIT_W-1:0] cfg_init_mask,
    input  logic [NU*INIT_W-1:0] cfg_init_match,
    input  logic [NU*TGT_W-1:0]  cfg_tgt_mask,
    input  logic [NU*TGT_W-1:0]  cfg_tgt_match,
    input  logic [NU*USER_W-1:0] cfg_user_mask,
    input  logic [NU*USER_W-1:0] cfg_user_match,
    input  logic [NU*ERR_W-1:0]  cfg_err_mask,
    input  logic [NU*ERR_W-1:0]  cfg_err_match,
    input  logic [NU-1:0]        cfg_rd_en,
    input  logic [NU-1:0]        cfg_wr_en,
    output logic [NU-1:0]        hit_o
);
    txn_t          txn;
    logic [NU-1:0] unit_pass;

    always_comb begin
        txn.init_id  = txn_init_id;
        txn.tgt_id   = txn_tgt_id;
        txn.user     = txn_user;
        txn.is_store = txn_store;
        txn.err      = txn_err;
    end

    for (genvar u = 0; u < NU; u++) begin : g_unit
        unit_cfg_t cfg;
        always_comb begin
            cfg.init_mask  = cfg_init_mask [u*INIT_W +: INIT_W];
            cfg.init_match = cfg_init_match[u*INIT_W +: INIT_W];
            cfg.tgt_mask   = cfg_tgt_mask  [u*TGT_W  +: TGT_W];
            cfg.tgt_match  = cfg_tgt_match [u*TGT_W  +: TGT_W];
            cfg.user_mask  = cfg_user_mask [u*USER_W +: USER_W];
            cfg.user_match = cfg_user_match[u*USER_W +: USER_W];
            cfg.err_mask   = cfg_err_mask  [u*ERR_W  +: ERR_W];
            cfg.err_match  = cfg_err_match [u*ERR_W  +: ERR_W];
            cfg.rd_en      = cfg_rd_en[u];
            cfg.wr_en      = cfg_wr_en[u];
        end

        trf_unit u_unit (
            .txn_i (txn),
            .cfg_i (cfg),
            .pass_o(unit_pass[u])
        );

        // Opcode with both enables off never produces a hit
        p_opcode_off_r7: assert property (@(posedge clk) disable iff (rst)
            $past(!cfg_rd_en[u] && !cfg_wr_en[u]) |-> !hit_o[u]);

        // A hit implies the initiator field compared equal under mask
        p_init_field_r2: assert property (@(posedge clk) disable iff (rst)
            hit_o[u] |-> $past(((txn_init_id ^ cfg_init_match[u*INIT_W +: INIT_W])
                                & cfg_init_mask[u*INIT_W +: INIT_W]) == '0));

        // A hit implies the error field compared equal under mask
        p_err_field_r5: assert property (@(posedge clk) disable iff (rst)
            hit_o[u] |-> $past(((txn_err ^ cfg_err_match[u*ERR_W +: ERR_W])
                                & cfg_err_mask[u*ERR_W +: ERR_W]) == '0));
    end

    always_ff @(posedge clk) begin
        if (rst)
            hit_o <= '0;
        else
            hit_o <= txn_valid ? unit_pass : '0;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (hit_o == '0));

    p_valid_gate_r9: assert property (@(posedge clk) disable iff (rst)
        $past(!txn_valid) |-> (hit_o == '0));

    p_latency_r10: assert property (@(posedge clk) disable iff (rst)
        (hit_o != '0) |-> $past(txn_valid));

endmodule

// File: tb/trf_filter_tb.sv
module trf_filter_tb;
    import trf_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NU = NUM_UNITS;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 txn_valid = 1'b0;
    logic [INIT_W-1:0]    txn_init_id = '0;
    logic [TGT_W-1:0]     txn_tgt_id = '0;
    logic [USER_W-1:0]    txn_user = '0;
    logic                 txn_store = 1'b0;
    logic [ERR_W-1:0]     txn_err = '0;
    logic [NU*INIT_W-1:0] cfg_init_mask = '0, cfg_init_match = '0;
    logic [NU*TGT_W-1:0]  cfg_tgt_mask = '0, cfg_tgt_match = '0;
    logic [NU*USER_W-1:0] cfg_user_mask = '0, cfg_user_match = '0;
    logic [NU*ERR_W-1:0]  cfg_err_mask = '0, cfg_err_match = '0;
    logic [NU-1:0]        cfg_rd_en = '0, cfg_wr_en = '0;
    logic [NU-1:0]        hit_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trf_filter u_dut (
        .clk(clk), .rst(rst), .txn_valid(txn_valid),
        .txn_init_id(txn_init_id), .txn_tgt_id(txn_tgt_id),
        .txn_user(txn_user), .txn_store(txn_store), .txn_err(txn_err),
        .cfg_init_mask(cfg_init_mask), .cfg_init_match(cfg_init_match),
        .cfg_tgt_mask(cfg_tgt_mask), .cfg_tgt_match(cfg_tgt_match),
        .cfg_user_mask(cfg_user_mask), .cfg_user_match(cfg_user_match),
        .cfg_err_mask(cfg_err_mask), .cfg_err_match(cfg_err_match),
        .cfg_rd_en(cfg_rd_en), .cfg_wr_en(cfg_wr_en), .hit_o(hit_o)
    );

    // Reference model computed from the requirements
    function automatic logic [NU-1:0] model();
        logic [NU-1:0] r;
        for (int u = 0; u < NU; u++) begin
            logic ok;
            ok = (((txn_init_id ^ cfg_init_match[u*INIT_W +: INIT_W]) & cfg_init_mask[u*INIT_W +: INIT_W]) == 0)
              && (((txn_tgt_id ^ cfg_tgt_match[u*TGT_W +: TGT_W]) & cfg_tgt_mask[u*TGT_W +: TGT_W]) == 0)
              && (((txn_user ^ cfg_user_match[u*USER_W +: USER_W]) & cfg_user_mask[u*USER_W +: USER_W]) == 0)
              && (((txn_err ^ cfg_err_match[u*ERR_W +: ERR_W]) & cfg_err_mask[u*ERR_W +: ERR_W]) == 0);
            if (txn_store) ok = ok && cfg_wr_en[u];
            else           ok = ok && cfg_rd_en[u];
            r[u] = ok && txn_valid;
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [NU-1:0] act, input logic [NU-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: hit_o actual %b expected %b", req, act, exp);
        end
    endtask

    // Inputs already driven; wait one edge, sample after it
    task automatic step_check(input string req);
        logic [NU-1:0] e;
        e = model();
        @(posedge clk);
        #1;
        chk(req, hit_o, e);
        @(negedge clk);
    endtask

    task automatic set_txn(input logic v, input logic [7:0] ini, input logic [6:0] tgt,
                           input logic [3:0] usr, input logic st, input logic [1:0] er);
        txn_valid = v; txn_init_id = ini; txn_tgt_id = tgt;
        txn_user = usr; txn_store = st; txn_err = er;
    endtask

    // Exact-match configuration for unit u against current transaction
    task automatic cfg_exact(input int u);
        cfg_init_mask[u*INIT_W +: INIT_W] = '1; cfg_init_match[u*INIT_W +: INIT_W] = txn_init_id;
        cfg_tgt_mask[u*TGT_W +: TGT_W]    = '1; cfg_tgt_match[u*TGT_W +: TGT_W]    = txn_tgt_id;
        cfg_user_mask[u*USER_W +: USER_W] = '1; cfg_user_match[u*USER_W +: USER_W] = txn_user;
        cfg_err_mask[u*ERR_W +: ERR_W]    = '1; cfg_err_match[u*ERR_W +: ERR_W]    = txn_err;
        cfg_rd_en[u] = 1'b1; cfg_wr_en[u] = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD*150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        // R1: reset clears output, even with a matching valid transaction
        set_txn(1, 8'hDE, 7'h42, 4'hA, 0, 2'b01);
        cfg_exact(0); cfg_exact(1);
        @(negedge clk); @(posedge clk); #1;
        chk("R1", hit_o, '0);
        @(negedge clk);
        rst = 1'b0;

        // R10: full match appears one cycle later
        step_check("R10");
        chk("R10 both hit", hit_o, 2'b11);

        // R9: valid low forces zero
        txn_valid = 0;
        step_check("R9");
        txn_valid = 1;

        // R2..R5: one-bit miss in each field on unit 0 only
        cfg_init_match[0 +: INIT_W] = txn_init_id ^ 8'h80; step_check("R2");
        chk("R2 unit0 miss", hit_o, 2'b10);
        cfg_exact(0);
        cfg_tgt_match[0 +: TGT_W] = txn_tgt_id ^ 7'h01; step_check("R3");
        chk("R3 unit0 miss", hit_o, 2'b10);
        cfg_exact(0);
        cfg_user_match[0 +: USER_W] = txn_user ^ 4'h4; step_check("R4");
        chk("R4 unit0 miss", hit_o, 2'b10);
        cfg_exact(0);
        cfg_err_match[0 +: ERR_W] = txn_err ^ 2'b10; step_check("R5");
        chk("R5 unit0 miss", hit_o, 2'b10);
        // R5: masked-off differing bit passes
        cfg_err_mask[0 +: ERR_W] = 2'b01; step_check("R5 masked");
        chk("R5 masked pass", hit_o, 2'b11);
        cfg_exact(0);

        // R6: zero masks, arbitrary match values
        cfg_init_mask = '0; cfg_tgt_mask = '0; cfg_user_mask = '0; cfg_err_mask = '0;
        cfg_init_match = '1; cfg_tgt_match = '0; cfg_user_match = '1; cfg_err_match = '1;
        step_check("R6");
        chk("R6 all pass", hit_o, 2'b11);

        // R7: opcode qualifiers
        cfg_rd_en = 2'b01; cfg_wr_en = 2'b10; txn_store = 0; step_check("R7 load");
        chk("R7 load only unit0", hit_o, 2'b01);
        txn_store = 1; step_check("R7 store");
        chk("R7 store only unit1", hit_o, 2'b10);
        cfg_rd_en = 2'b00; cfg_wr_en = 2'b00; step_check("R7 off store");
        txn_store = 0; step_check("R7 off load");
        chk("R7 none", hit_o, 2'b00);

        // R8 / R11: units disagree on the same transaction
        set_txn(1, 8'h68, 7'h14, 4'h3, 1, 2'b00);
        cfg_exact(0); cfg_exact(1);
        cfg_tgt_match[TGT_W +: TGT_W] = 7'h15;
        step_check("R11");
        chk("R11 unit0 only", hit_o, 2'b01);
        cfg_exact(1); cfg_init_mask[0 +: INIT_W] = 8'h0F; cfg_init_match[0 +: INIT_W] = 8'hF9;
        step_check("R8");
        chk("R8 low nibble differs", hit_o, 2'b10);

        // R8/R2-R5 random: copy fields into match then flip bits
        for (int n = 0; n < 600; n++) begin
            set_txn($urandom_range(0, 7) != 0, $urandom, $urandom, $urandom, $urandom, $urandom);
            for (int u = 0; u < NU; u++) begin
                cfg_init_mask[u*INIT_W +: INIT_W] = $urandom;
                cfg_tgt_mask[u*TGT_W +: TGT_W]    = $urandom;
                cfg_user_mask[u*USER_W +: USER_W] = $urandom;
                cfg_err_mask[u*ERR_W +: ERR_W]    = $urandom;
                cfg_init_match[u*INIT_W +: INIT_W] = txn_init_id ^
                    (($urandom_range(0, 5) == 0) ? (8'h1 << $urandom_range(0, 7)) : 8'h0);
                cfg_tgt_match[u*TGT_W +: TGT_W] = txn_tgt_id ^
                    (($urandom_range(0, 5) == 0) ? (7'h1 << $urandom_range(0, 6)) : 7'h0);
                cfg_user_match[u*USER_W +: USER_W] = txn_user ^
                    (($urandom_range(0, 5) == 0) ? (4'h1 << $urandom_range(0, 3)) : 4'h0);
                cfg_err_match[u*ERR_W +: ERR_W] = txn_err ^
                    (($urandom_range(0, 5) == 0) ? (2'h1 << $urandom_range(0, 1)) : 2'h0);
                cfg_rd_en[u] = $urandom_range(0, 3) != 0;
                cfg_wr_en[u] = $urandom_range(0, 3) != 0;
            end
            step_check("R8 random");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule